// File: doc/BRIEF.md
# SIMD Array Instruction Dispatcher

This block is the control unit of a small SIMD machine together with its processing-element array. A host first writes a routine into the local program memory, then gives a start pulse with an entry address. From that point the controller fetches and decodes every instruction by itself. The host runs no code until the done pulse arrives. Each instruction belongs to one of two classes. A scalar instruction runs only on the controller's own register file and adder. A parallel instruction goes out on a broadcast bus in the cycle it is decoded. Every element then executes it at the same clock edge on its own register bank and local memory.

The elements contain no fetch or decode logic. Each one holds a bank of forty 32-bit registers, a small local memory and an active flag. A parallel compare sets the active flag, and a set-all instruction raises it again. An element whose flag is low ignores broadcast writes to its registers and to its memory. One instruction issues per cycle. A scalar write reaches the controller register file one cycle after it executes. For that reason, a following instruction that reads the same register, including a scalar-to-array broadcast, takes the value from the pending write.

Top module: `simd_dispatch`

## Requirements
- R1: After reset, busy_o, done_o, sc_wb_valid_o and every bit of pe_wb_valid_o are low, and every bit of pe_active_o is high.
- R2: The start pulse is accepted only while the block is idle, and it loads the program counter from start_pc_i. Instruction k after the entry executes in the k-th cycle after the accepting edge. When a halt executes, busy_o falls and done_o is high for exactly one cycle, starting at the edge after the halt.
- R3: Instruction word layout: bit 31 is the class (0 scalar, 1 parallel), bits 30:27 the operation, bits 26:21 the destination register, bits 20:15 the source register, and bits 14:0 an immediate that is zero-extended.
- R4: Scalar operations are 0 load-immediate, 1 add register, 2 add immediate and 3 halt. Each writing scalar operation shows its result on sc_wb_valid_o/sc_wb_data_o one cycle after it executes and produces no element output.
- R5: A parallel operation executes on every active element at the same edge. Each element's register write appears on its pe_wb_valid_o bit and pe_wb_data_o lane (lane p at bits 32p+31:32p) in the cycle after. The operations are 0 load-immediate, 1 add register and 2 add immediate.
- R6: Parallel operation 8 writes the element's own index into the destination register, so each lane receives a distinct value.
- R7: Parallel operation 4 stores the destination register to local memory at the immediate address. Operation 5 loads that address into the destination register. Local memory is zero after reset.
- R8: Parallel operation 6 is evaluated on every element and sets its active flag to (destination register == immediate). An element with a low flag ignores register and memory writes.
- R9: Parallel operation 7 sets every active flag high.
- R10: Parallel operation 3 writes the scalar register named by the source field into the destination register of each active element. If the previous instruction wrote that scalar register, the new value is used. A scalar add that reads the previous scalar result is forwarded in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_we_i | input | 1 | Program memory write enable |
| prog_addr_i | input | PC_W | Program memory write address |
| prog_data_i | input | 32 | Program memory write data |
| start_i | input | 1 | Start pulse from host |
| start_pc_i | input | PC_W | Entry address of the routine |
| busy_o | output | 1 | Routine running |
| done_o | output | 1 | One-cycle pulse after halt |
| sc_wb_valid_o | output | 1 | Scalar result valid |
| sc_wb_data_o | output | 32 | Scalar result |
| pe_wb_valid_o | output | NUM_PE | Per-element register write valid |
| pe_wb_data_o | output | NUM_PE*32 | Per-element register write data |
| pe_active_o | output | NUM_PE | Per-element active flags |

## Verification
The hardest case to bring about is a scalar result that is still pending, so it has not yet reached the controller register file, while the next instruction reads it. Reaching it needs a scalar write followed directly by a scalar-to-array broadcast or a dependent scalar add, and the stimulus places both pairs back to back. Masking is checked by writing through a partial active set. The stored word is then read back after all elements are re-enabled, and a second routine with no element active shows that the write never happened.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int XLEN = 32;

  typedef enum logic [3:0] {
    S_LI   = 4'd0,
    S_ADD  = 4'd1,
    S_ADDI = 4'd2,
    S_HALT = 4'd3
  } sop_e;

  typedef enum logic [3:0] {
    P_LI     = 4'd0,
    P_ADD    = 4'd1,
    P_ADDI   = 4'd2,
    P_BCAST  = 4'd3,
    P_ST     = 4'd4,
    P_LD     = 4'd5,
    P_CMPEQ  = 4'd6,
    P_SETALL = 4'd7,
    P_ID     = 4'd8
  } pop_e;

  typedef struct packed {
    logic            valid;
    pop_e            op;
    logic [5:0]      rd;
    logic [5:0]      rs;
    logic [XLEN-1:0] imm;
  } bcast_t;
endpackage

// File: rtl/simd_fetch_decode.sv
module simd_fetch_decode #(
  parameter int PROG_DEPTH = 64,
  localparam int PC_W = $clog2(PROG_DEPTH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            prog_we_i,
  input  logic [PC_W-1:0] prog_addr_i,
  input  logic [31:0]     prog_data_i,
  input  logic            start_i,
  input  logic [PC_W-1:0] start_pc_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            issue_o,
  output logic [31:0]     instr_o
);
  import simd_pkg::*;

  logic [31:0]     imem [PROG_DEPTH];
  logic [PC_W-1:0] pc_q;
  logic            busy_q, done_q, halt;

  always_ff @(posedge clk_i) begin
    if (prog_we_i) imem[prog_addr_i] <= prog_data_i;
  end

  assign instr_o = imem[pc_q];
  assign issue_o = busy_q;
  assign halt    = busy_q && !instr_o[31] && (sop_e'(instr_o[30:27]) == S_HALT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q && start_i) begin
        pc_q   <= start_pc_i;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (halt) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          pc_q <= pc_q + 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/simd_scalar_unit.sv
module simd_scalar_unit #(
  parameter int NREG = 16,
  localparam int RW = $clog2(NREG)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        issue_i,
  input  logic [31:0] instr_i,
  output logic        wb_valid_o,
  output logic [31:0] wb_data_o,
  output logic [31:0] rs_fwd_o
);
  import simd_pkg::*;

  logic [31:0] rf [NREG];
  logic        wb_valid_q;
  logic [5:0]  wb_idx_q;
  logic [31:0] wb_data_q;

  logic [5:0]  rd_idx, rs_idx;
  logic [31:0] imm, rd_val, rs_val, res;
  logic        wr;

  // reads see the pending write-back first
  function automatic logic [31:0] rd_fwd(input logic [5:0] idx);
    if (wb_valid_q && wb_idx_q == idx) return wb_data_q;
    if (int'(idx) < NREG) return rf[idx[RW-1:0]];
    return '0;
  endfunction

  assign rd_idx = instr_i[26:21];
  assign rs_idx = instr_i[20:15];
  assign imm    = {17'b0, instr_i[14:0]};
  assign rd_val = rd_fwd(rd_idx);
  assign rs_val = rd_fwd(rs_idx);
  assign rs_fwd_o = rs_val;

  always_comb begin
    wr  = 1'b0;
    res = '0;
    if (issue_i && !instr_i[31]) begin
      unique case (sop_e'(instr_i[30:27]))
        S_LI:    begin res = imm;           wr = 1'b1; end
        S_ADD:   begin res = rd_val + rs_val; wr = 1'b1; end
        S_ADDI:  begin res = rd_val + imm;  wr = 1'b1; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_valid_q <= 1'b0;
      wb_idx_q   <= '0;
      wb_data_q  <= '0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      if (wb_valid_q && int'(wb_idx_q) < NREG) rf[wb_idx_q[RW-1:0]] <= wb_data_q;
      wb_valid_q <= wr;
      wb_idx_q   <= rd_idx;
      wb_data_q  <= res;
    end
  end

  assign wb_valid_o = wb_valid_q;
  assign wb_data_o  = wb_data_q;
endmodule

// File: rtl/simd_pe.sv
module simd_pe #(
  parameter int ID        = 0,
  parameter int NREG      = 40,
  parameter int MEM_DEPTH = 16,
  localparam int RW = $clog2(NREG),
  localparam int MW = $clog2(MEM_DEPTH)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  simd_pkg::bcast_t       bcast_i,
  output logic                   active_o,
  output logic                   wb_valid_o,
  output logic [31:0]            wb_data_o
);
  import simd_pkg::*;

  logic [31:0] rf  [NREG];
  logic [31:0] mem [MEM_DEPTH];
  logic        active_q, wb_valid_q;
  logic [31:0] wb_data_q;

  logic          rd_ok;
  logic [31:0]   rd_val, rs_val, res;
  logic [MW-1:0] addr;
  logic          wr_reg, wr_mem;

  assign rd_ok  = int'(bcast_i.rd) < NREG;
  assign rd_val = rd_ok ? rf[bcast_i.rd[RW-1:0]] : '0;
  assign rs_val = (int'(bcast_i.rs) < NREG) ? rf[bcast_i.rs[RW-1:0]] : '0;
  assign addr   = bcast_i.imm[MW-1:0];

  always_comb begin
    res    = '0;
    wr_reg = 1'b0;
    wr_mem = 1'b0;
    if (bcast_i.valid) begin
      unique case (bcast_i.op)
        P_LI:    begin res = bcast_i.imm;          wr_reg = 1'b1; end
        P_ADD:   begin res = rd_val + rs_val;      wr_reg = 1'b1; end
        P_ADDI:  begin res = rd_val + bcast_i.imm; wr_reg = 1'b1; end
        P_BCAST: begin res = bcast_i.imm;          wr_reg = 1'b1; end
        P_LD:    begin res = mem[addr];            wr_reg = 1'b1; end
        P_ID:    begin res = 32'(ID);              wr_reg = 1'b1; end
        P_ST:    wr_mem = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b1;
      wb_valid_q <= 1'b0;
      wb_data_q  <= '0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
      for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= '0;
    end else begin
      wb_valid_q <= wr_reg && active_q && rd_ok;
      wb_data_q  <= res;
      if (wr_reg && active_q && rd_ok) rf[bcast_i.rd[RW-1:0]] <= res;
      if (wr_mem && active_q) mem[addr] <= rd_val;
      // compare is evaluated by every element, masked or not
      if (bcast_i.valid && bcast_i.op == P_CMPEQ) active_q <= (rd_val == bcast_i.imm);
      if (bcast_i.valid && bcast_i.op == P_SETALL) active_q <= 1'b1;
    end
  end

  assign active_o   = active_q;
  assign wb_valid_o = wb_valid_q;
  assign wb_data_o  = wb_data_q;
endmodule

// File: rtl/simd_dispatch.sv
module simd_dispatch #(
  parameter int NUM_PE     = 4,
  parameter int PROG_DEPTH = 64,
  parameter int SC_NREG    = 16,
  parameter int PE_NREG    = 40,
  parameter int PE_MEM     = 16,
  localparam int PC_W = $clog2(PROG_DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 prog_we_i,
  input  logic [PC_W-1:0]      prog_addr_i,
  input  logic [31:0]          prog_data_i,
  input  logic                 start_i,
  input  logic [PC_W-1:0]      start_pc_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 sc_wb_valid_o,
  output logic [31:0]          sc_wb_data_o,
  output logic [NUM_PE-1:0]    pe_wb_valid_o,
  output logic [NUM_PE*32-1:0] pe_wb_data_o,
  output logic [NUM_PE-1:0]    pe_active_o
);
  import simd_pkg::*;

  logic        issue;
  logic [31:0] instr, sc_fwd;
  bcast_t      bcast;

  simd_fetch_decode #(.PROG_DEPTH(PROG_DEPTH)) u_fetch (
    .clk_i, .rst_ni, .prog_we_i, .prog_addr_i, .prog_data_i,
    .start_i, .start_pc_i, .busy_o, .done_o,
    .issue_o(issue), .instr_o(instr)
  );

  simd_scalar_unit #(.NREG(SC_NREG)) u_scalar (
    .clk_i, .rst_ni, .issue_i(issue), .instr_i(instr),
    .wb_valid_o(sc_wb_valid_o), .wb_data_o(sc_wb_data_o), .rs_fwd_o(sc_fwd)
  );

  always_comb begin
    bcast.valid = issue && instr[31];
    bcast.op    = pop_e'(instr[30:27]);
    bcast.rd    = instr[26:21];
    bcast.rs    = instr[20:15];
    bcast.imm   = (bcast.op == P_BCAST) ? sc_fwd : {17'b0, instr[14:0]};
  end

  for (genvar p = 0; p < NUM_PE; p++) begin : g_pe
    simd_pe #(.ID(p), .NREG(PE_NREG), .MEM_DEPTH(PE_MEM)) u_pe (
      .clk_i, .rst_ni, .bcast_i(bcast),
      .active_o(pe_active_o[p]),
      .wb_valid_o(pe_wb_valid_o[p]),
      .wb_data_o(pe_wb_data_o[p*32 +: 32])
    );
  end
endmodule

// File: rtl/simd_dispatch_chk.sv
module simd_dispatch_chk #(
  parameter int NUM_PE = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              sc_wb_valid_o,
  input logic [NUM_PE-1:0] pe_wb_valid_o,
  input logic [NUM_PE-1:0] pe_active_o
);
  assert_done_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_done_after_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_scalar_not_bcast_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_wb_valid_o |-> pe_wb_valid_o == '0);

  assert_idle_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> pe_wb_valid_o == '0 && !sc_wb_valid_o);

  assert_masked_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pe_wb_valid_o & ~$past(pe_active_o)) == '0);
endmodule

bind simd_dispatch simd_dispatch_chk #(.NUM_PE(NUM_PE)) u_chk (
  .clk_i, .rst_ni, .busy_o, .done_o, .sc_wb_valid_o, .pe_wb_valid_o, .pe_active_o
);

// File: tb/simd_dispatch_tb.sv
module simd_dispatch_tb;
  localparam int NPE = 4;
  localparam int PCW = 6;

  logic             clk_i = 1'b0, rst_ni = 1'b0;
  logic             prog_we_i = 1'b0;
  logic [PCW-1:0]   prog_addr_i = '0;
  logic [31:0]      prog_data_i = '0;
  logic             start_i = 1'b0;
  logic [PCW-1:0]   start_pc_i = '0;
  logic             busy_o, done_o, sc_wb_valid_o;
  logic [31:0]      sc_wb_data_o;
  logic [NPE-1:0]   pe_wb_valid_o, pe_active_o;
  logic [NPE*32-1:0] pe_wb_data_o;

  always #10ns clk_i = ~clk_i;

  simd_dispatch #(.NUM_PE(NPE)) u_dut (.*);

  int n_chk = 0, n_bad = 0;
  int exp_ch[$];
  logic [31:0] exp_dat[$];
  string exp_req[$];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver side: expected result on channel (lane index, NPE = scalar)
  task automatic expect_item(string req, int ch, logic [31:0] d);
    exp_req.push_back(req);
    exp_ch.push_back(ch);
    exp_dat.push_back(d);
  endtask

  task automatic monitor_pop(int ch, logic [31:0] d);
    if (exp_ch.size() == 0) begin
      check("R4/R5 unexpected write", 32'(ch), 32'hFFFF_FFFF);
    end else begin
      string r = exp_req.pop_front();
      int    c = exp_ch.pop_front();
      logic [31:0] e = exp_dat.pop_front();
      check({r, " channel"}, 32'(ch), 32'(c));
      check({r, " data"}, d, e);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni) begin
      for (int p = 0; p < NPE; p++)
        if (pe_wb_valid_o[p]) monitor_pop(p, pe_wb_data_o[p*32 +: 32]);
      if (sc_wb_valid_o) monitor_pop(NPE, sc_wb_data_o);
    end
  end

  function automatic logic [31:0] enc(bit par, int op, int rd, int rs, int imm);
    return {par, 4'(op), 6'(rd), 6'(rs), 15'(imm)};
  endfunction

  task automatic load(int a, logic [31:0] w);
    @(negedge clk_i);
    prog_we_i = 1'b1; prog_addr_i = PCW'(a); prog_data_i = w;
    @(negedge clk_i);
    prog_we_i = 1'b0;
  endtask

  task automatic run(int pc, int exp_cycles);
    int n = 0;
    @(negedge clk_i);
    start_i = 1'b1; start_pc_i = PCW'(pc);
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    n = 1;
    while (!done_o && n < 200) begin
      @(negedge clk_i);
      n++;
    end
    check("R2 cycles to done", 32'(n), 32'(exp_cycles));
    check("R2 busy low at done", 32'(busy_o), 32'd0);
    @(negedge clk_i);
    check("R2 done one cycle", 32'(done_o), 32'd0);
  endtask

  initial begin
    #(20ns * 100000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 busy", 32'(busy_o), 0);
    check("R1 done", 32'(done_o), 0);
    check("R1 wb valid", {27'b0, sc_wb_valid_o, pe_wb_valid_o}, 0);
    check("R1 active", 32'(pe_active_o), 32'hF);
    rst_ni = 1'b1;

    // routine A (R3 layout: class, op, rd, rs, imm)
    load(0,  enc(1, 8, 1, 0, 0));    // id
    load(1,  enc(1, 2, 1, 0, 10));   // addi
    load(2,  enc(0, 0, 2, 0, 100));  // scalar li
    load(3,  enc(1, 3, 2, 2, 0));    // broadcast s2, forwarded
    load(4,  enc(1, 6, 1, 0, 12));   // cmpeq
    load(5,  enc(1, 1, 2, 1, 0));    // add masked
    load(6,  enc(1, 4, 2, 0, 3));    // store masked
    load(7,  enc(1, 7, 0, 0, 0));    // setall
    load(8,  enc(1, 5, 3, 0, 3));    // load
    load(9,  enc(0, 2, 2, 0, 5));    // scalar addi
    load(10, enc(0, 1, 3, 2, 0));    // scalar add, forwarded
    load(11, enc(0, 3, 0, 0, 0));    // halt
    // routine B
    load(20, enc(1, 6, 1, 0, 99));
    load(21, enc(1, 0, 1, 0, 7));
    load(22, enc(1, 7, 0, 0, 0));
    load(23, enc(1, 2, 1, 0, 0));
    load(24, enc(0, 3, 0, 0, 0));

    for (int p = 0; p < NPE; p++) expect_item("R6 element id", p, 32'(p));
    for (int p = 0; p < NPE; p++) expect_item("R5 addi", p, 32'(p + 10));
    expect_item("R4 scalar li", NPE, 100);
    for (int p = 0; p < NPE; p++) expect_item("R10 bcast forward", p, 100);
    expect_item("R8 masked add", 2, 112);
    for (int p = 0; p < NPE; p++) expect_item("R7 load after masked store", p, (p == 2) ? 112 : 0);
    expect_item("R4 scalar addi", NPE, 105);
    expect_item("R10 scalar add forward", NPE, 105);
    run(0, 13);
    check("R9 setall active", 32'(pe_active_o), 32'hF);

    for (int p = 0; p < NPE; p++) expect_item("R8 inactive ignored", p, 32'(p + 10));
    run(20, 6);
    check("R9 active after B", 32'(pe_active_o), 32'hF);
    repeat (3) @(negedge clk_i);
    check("R5 all expected seen", 32'(exp_ch.size()), 0);
    check("R2 idle after done", 32'(busy_o), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule